// File: doc/BRIEF.md
# Linear Frequency Ramp Generator

This block moves a frequency control word from its present value to a new target along a straight line. A single-cycle `start` captures three things at once: the present word, the target word and a rate select code. The block then forms the signed difference between the target and the present word. It divides the magnitude of that difference by the per-tick increment chosen by the code. This gives, before any movement begins, the number of full steps and whether a final correction step is needed.

During the ramp the output moves by exactly one increment toward the target on each cycle in which `tick` is high. Once the full steps are used up, one more tick loads the target directly if a remainder is left over. The ramp therefore always ends exactly on the target. `done` then pulses for one cycle. The rate table is computed from parameters and does not depend on any loop-filter setting.

All pins are plain control and data pins with no back-pressure. `start` is accepted only while `busy` is low, and the inputs are read only in the accepting cycle.

Top module: `freq_ramp_gen`

## Requirements
- R1: After reset, `out_word` is 0 and `busy` and `done` are both 0.
- R2: Rate code k selects the per-tick increment `BASE_INC * (4 + k mod 4) * 2^(k div 4)` for k below `NRATE` (default 40). Any code at or above `NRATE` behaves as code `NRATE-1`.
- R3: A `start` seen while idle loads `cur_word` into `out_word` at that clock edge. For a nonzero difference, `busy` is high from that edge on.
- R4: For a difference of magnitude D and increment I, the ramp makes exactly floor(D/I) steps, each moving `out_word` by exactly I toward the target.
- R5: When D mod I is nonzero, one extra step loads the target word directly. This also covers D smaller than I, which gives a ramp of only that one step.
- R6: A target below the present word makes the output step downward; a target above it makes the output step upward.
- R7: `out_word` changes during a ramp only at a clock edge where `tick` was high.
- R8: At the end of a ramp `done` is high for exactly one cycle. In that cycle `out_word` equals the target and `busy` is low.
- R9: When the target equals the present word, `done` is high in the cycle after `start`, `busy` stays low and `out_word` equals the target.
- R10: While busy, `start` and changes to `tgt_word`, `cur_word` or `rate_code` have no effect on the ramp in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a ramp (accepted only when idle) |
| cur_word | input | W | Present frequency word, latched on start |
| tgt_word | input | W | Target frequency word, latched on start |
| rate_code | input | RW | Rate select code, latched on start |
| tick | input | 1 | Step enable during a ramp |
| out_word | output | W | Ramped frequency word |
| busy | output | 1 | Ramp in progress (division or stepping) |
| done | output | 1 | One-cycle pulse when the ramp has landed on the target |

## Verification
The hardest case to reach is a mid-ramp disturbance. Here `start` pulses again while the block is busy, with a different target and rate code on the inputs. The bench has to show that neither the step size nor the landing point moves. The directed ramp task can raise `start` a few cycles into a ramp with a new target and code zero. It then classifies every observed output change as a full step, a final correction or an error. The same task runs with a sparse tick pattern, so that steps are seen to occur only after a tick.

// File: rtl/fr_pkg.sv
package fr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_RAMP = 2'd2
  } fr_state_e;
endpackage

// File: rtl/fr_rate_table.sv
module fr_rate_table #(
  parameter int W        = 32,
  parameter int RW       = 6,
  parameter int NRATE    = 40,
  parameter int BASE_INC = 1
) (
  input  logic [RW-1:0] code,
  output logic [W-1:0]  inc
);
  localparam logic [RW-1:0] TOP_CODE = RW'(NRATE - 1);

  function automatic logic [W-1:0] step_of(int idx);
    logic [W-1:0] m;
    m = W'(BASE_INC) * W'(4 + (idx % 4));
    return m << (idx / 4);
  endfunction

  logic [W-1:0] tbl [NRATE];

  for (genvar g = 0; g < NRATE; g++) begin : g_rate
    assign tbl[g] = step_of(g);
  end

  logic [RW-1:0] code_sat;
  assign code_sat = (code > TOP_CODE) ? TOP_CODE : code;
  assign inc      = tbl[code_sat];
endmodule

// File: rtl/fr_span.sv
module fr_span #(
  parameter int W = 32
) (
  input  logic [W-1:0] from_word,
  input  logic [W-1:0] to_word,
  output logic [W-1:0] mag,
  output logic         down,
  output logic         zero
);
  logic [W:0] diff;
  logic [W:0] negd;

  assign diff = {1'b0, to_word} - {1'b0, from_word};
  assign negd = ~diff + 1'b1;
  assign down = diff[W];
  assign mag  = down ? negd[W-1:0] : diff[W-1:0];
  assign zero = (from_word == to_word);
endmodule

// File: rtl/fr_divider.sv
module fr_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem,
  output logic         fin
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt;
  logic          running;
  logic [W-1:0]  dvs_q;
  logic [W:0]    shifted;
  logic [W:0]    trial;

  assign shifted = {rem, quot[W-1]};
  assign trial   = shifted - {1'b0, dvs_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
      dvs_q   <= '0;
      quot    <= '0;
      rem     <= '0;
      fin     <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        quot    <= dividend;
        rem     <= '0;
        dvs_q   <= divisor;
        cnt     <= CW'(W);
        running <= 1'b1;
      end else if (running) begin
        quot <= {quot[W-2:0], ~trial[W]};
        rem  <= trial[W] ? shifted[W-1:0] : trial[W-1:0];
        cnt  <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          running <= 1'b0;
          fin     <= 1'b1;
        end
      end
    end
  end

  // R4: a finished division leaves a remainder below the divisor
  p_rem_below_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (rem < dvs_q));
endmodule

// File: rtl/freq_ramp_gen.sv
module freq_ramp_gen
  import fr_pkg::*;
#(
  parameter int W        = 32,
  parameter int RW       = 6,
  parameter int NRATE    = 40,
  parameter int BASE_INC = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  cur_word,
  input  logic [W-1:0]  tgt_word,
  input  logic [RW-1:0] rate_code,
  input  logic          tick,
  output logic [W-1:0]  out_word,
  output logic          busy,
  output logic          done
);
  fr_state_e    state;
  logic [W-1:0] inc_sel, inc_q;
  logic [W-1:0] span_mag;
  logic         span_down, span_zero;
  logic         down_q, fix_q;
  logic [W-1:0] tgt_q, steps_q;
  logic [W-1:0] div_quot, div_rem;
  logic         div_fin;
  logic         accept, div_go;

  fr_rate_table #(.W(W), .RW(RW), .NRATE(NRATE), .BASE_INC(BASE_INC)) u_rate (
    .code (rate_code),
    .inc  (inc_sel)
  );

  fr_span #(.W(W)) u_span (
    .from_word (cur_word),
    .to_word   (tgt_word),
    .mag       (span_mag),
    .down      (span_down),
    .zero      (span_zero)
  );

  assign accept = start && (state == ST_IDLE);
  assign div_go = accept && !span_zero;

  fr_divider #(.W(W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (div_go),
    .dividend (span_mag),
    .divisor  (inc_sel),
    .quot     (div_quot),
    .rem      (div_rem),
    .fin      (div_fin)
  );

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      out_word <= '0;
      tgt_q    <= '0;
      inc_q    <= '0;
      down_q   <= 1'b0;
      steps_q  <= '0;
      fix_q    <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            tgt_q    <= tgt_word;
            inc_q    <= inc_sel;
            down_q   <= span_down;
            out_word <= cur_word;
            if (span_zero) begin
              done <= 1'b1;
            end else begin
              state <= ST_DIV;
            end
          end
        end
        ST_DIV: begin
          if (div_fin) begin
            steps_q <= div_quot;
            fix_q   <= (div_rem != '0);
            state   <= ST_RAMP;
          end
        end
        ST_RAMP: begin
          if (steps_q == '0 && !fix_q) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else if (tick) begin
            if (steps_q != '0) begin
              out_word <= down_q ? (out_word - inc_q) : (out_word + inc_q);
              steps_q  <= steps_q - 1'b1;
            end else begin
              out_word <= tgt_q;
              fix_q    <= 1'b0;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: done lasts a single cycle
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: done coincides with the target on the output
  p_done_on_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (out_word == tgt_q));

  // R8: busy is low while done is reported
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7: no tick during a ramp leaves the output unchanged
  p_hold_without_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RAMP && !tick) |=> $stable(out_word));

  // R10: a start during a ramp does not disturb the latched target
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(tgt_q));

  // R9: equal words finish on the next cycle
  p_zero_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cur_word == tgt_word) |=> done);
endmodule

// File: tb/freq_ramp_gen_bench.sv
module freq_ramp_gen_bench;
  localparam int W = 32;
  localparam int RW = 6;
  localparam int NRATE = 40;
  localparam int BASE_INC = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  cur_word = '0;
  logic [W-1:0]  tgt_word = '0;
  logic [RW-1:0] rate_code = '0;
  logic          tick = 1'b0;
  logic [W-1:0]  out_word;
  logic          busy, done;

  int total = 0;
  int bad = 0;

  freq_ramp_gen #(.W(W), .RW(RW), .NRATE(NRATE), .BASE_INC(BASE_INC)) u_freq_ramp_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .cur_word(cur_word), .tgt_word(tgt_word),
    .rate_code(rate_code), .tick(tick), .out_word(out_word), .busy(busy), .done(done)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint inc_of(input int code);
    int k;
    k = (code >= NRATE) ? NRATE - 1 : code;
    return longint'(BASE_INC) * (4 + (k % 4)) * (longint'(1) << (k / 4));
  endfunction

  task automatic run_ramp(input longint c, input longint t, input int code,
                          input int tick_every, input bit disturb, input string req);
    longint inc, mag, q, r, prev, o, d;
    int n_full, n_fix, n_bad, n_viol, n_done;
    bit t_used, down, finished;
    inc  = inc_of(code);
    down = (t < c);
    mag  = down ? c - t : t - c;
    q    = mag / inc;
    r    = mag % inc;
    n_full = 0; n_fix = 0; n_bad = 0; n_viol = 0; n_done = 0;
    finished = 1'b0;
    cur_word = W'(c); tgt_word = W'(t); rate_code = RW'(code); start = 1'b1; tick = 1'b0;
    @(posedge clk); #1;
    start = 1'b0;
    check(busy == 1'b1, "R3 busy after start", longint'(busy), 1);
    check(out_word == W'(c), "R3 output loaded", longint'(out_word), c);
    prev = c;
    for (int cyc = 0; cyc < 5000 && !finished; cyc++) begin
      if (disturb && cyc == 3) begin
        start = 1'b1; tgt_word = W'(t + 777); cur_word = '0; rate_code = '0;
      end else begin
        start = 1'b0;
      end
      tick = ((cyc % tick_every) == 0);
      t_used = tick;
      @(posedge clk); #1;
      o = longint'(out_word);
      if (o != prev) begin
        if (!t_used) n_viol++;
        d = down ? prev - o : o - prev;
        if (d == inc) n_full++;
        else if (o == t && d > 0 && d < inc) n_fix++;
        else n_bad++;
        prev = o;
      end
      if (done) begin
        n_done++;
        finished = 1'b1;
        check(out_word == W'(t), {req, " R8 lands on target"}, longint'(out_word), t);
        check(busy == 1'b0, {req, " R8 busy low at done"}, longint'(busy), 0);
      end
    end
    start = 1'b0; tick = 1'b0;
    check(finished, {req, " R8 ramp finished"}, longint'(finished), 1);
    check(n_full == q, {req, " R4 full step count"}, n_full, q);
    check(n_fix == (r != 0 ? 1 : 0), {req, " R5 correction step"}, n_fix, (r != 0 ? 1 : 0));
    check(n_bad == 0, {req, " R6 step direction and size"}, n_bad, 0);
    check(n_viol == 0, {req, " R7 step without tick"}, n_viol, 0);
    @(posedge clk); #1;
    check(done == 1'b0, {req, " R8 done single cycle"}, longint'(done), 0);
    check(out_word == W'(t), {req, " R10 target kept"}, longint'(out_word), t);
  endtask

  task automatic test_reset();
    check(out_word == '0, "R1 out reset", longint'(out_word), 0);
    check(busy == 1'b0, "R1 busy reset", longint'(busy), 0);
    check(done == 1'b0, "R1 done reset", longint'(done), 0);
  endtask

  task automatic test_zero();
    cur_word = 32'd4321; tgt_word = 32'd4321; rate_code = 6'd10; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    check(done == 1'b1, "R9 done next cycle", longint'(done), 1);
    check(busy == 1'b0, "R9 busy stays low", longint'(busy), 0);
    check(out_word == 32'd4321, "R9 output equals target", longint'(out_word), 4321);
    @(posedge clk); #1;
    check(done == 1'b0, "R9 done single cycle", longint'(done), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    test_reset();
    rst_n = 1'b1;
    @(posedge clk); #1;
    run_ramp(1000, 2000, 20, 1, 1'b0, "up remainder R2");
    run_ramp(5000, 3000, 8, 1, 1'b0, "down exact R6");
    run_ramp(200, 205, 4, 1, 1'b0, "below increment R5");
    run_ramp(10, 100010, 63, 1, 1'b0, "saturated code R2");
    run_ramp(900, 100, 9, 3, 1'b0, "sparse ticks R7");
    run_ramp(50000, 52000, 12, 1, 1'b1, "disturbed R10");
    test_zero();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule